// File: doc/BRIEF.md
# Glitch-Free Four-Source Master Clock Controller

This block chooses the chip's master clock from four oscillator inputs: an external crystal, an external user clock, a fast internal RC oscillator and a slow internal RC oscillator. Software asks for a new source with a one-cycle write strobe. The controller waits for that source's ready flag, then hands the master clock over with a break-before-make handshake, so no shortened pulse appears on the output. A power-of-two prescaler derives the CPU clock from the master clock. A per-peripheral enable vector gates copies of the CPU clock to the peripherals.

A clock security monitor can be switched on by software. It counts fast RC cycles between rising edges of the crystal. When the count runs out, it latches a sticky failure flag. If the crystal was driving the master clock, or was the target of a switch in progress, the controller forces the master clock back to the fast RC and forces the prescaler to divide by 8. An interrupt line follows the flag when its enable is set. While the flag is set, the crystal cannot be reselected.

The control logic runs on the fast RC clock, which never stops. It uses a four-state machine:
- **ST_IDLE**: stable on the current source. An accepted write moves it to ST_WAIT. A security fallback moves it to ST_DROP.
- **ST_WAIT**: waits for the requested source's ready flag, then moves to ST_DROP.
- **ST_DROP**: all channel requests are withdrawn. It waits until every channel reports its gate closed, then moves to ST_RAISE.
- **ST_RAISE**: requests only the target channel. Once that channel reports its gate open, the target becomes the current source and the machine returns to ST_IDLE.

A fallback from ST_WAIT, ST_DROP or ST_RAISE while the crystal is the target also goes to ST_DROP, with the fast RC as the new target.

Top module: `clkctl`

## Requirements
- R1: Source codes are 0 crystal, 1 external user clock, 2 fast RC, 3 slow RC. After a completed switch, `cur_src_o` shows the code and `mclk_o` runs at that source's rate.
- R2: Out of reset, the master clock is the fast RC and the prescaler code is 3 (divide by 8). `busy_o`, `fail_o` and `irq_o` are low.
- R3: After a switch request, the master clock and `cur_src_o` stay on the old source until the requested source's ready flag (bit index = source code of `src_rdy_i`) is high.
- R4: No high or low pulse on `mclk_o` is shorter than the shortest half-period among the sources.
- R5: For prescaler code k (0..7), `cpu_clk_o` gives one high pulse per 2^k master clock cycles. A new code takes effect at a divided-period boundary.
- R6: With `css_en_i` low, the failure flag never sets. With it high, the flag sets when the crystal shows no rising edge for 64 consecutive fast RC cycles. A running crystal never sets it.
- R7: When the flag sets while the crystal drives the master clock, the master clock returns to the fast RC and the prescaler code is forced to 3.
- R8: `irq_o` is high exactly when the failure flag is set and `css_ie_i` is high.
- R9: The failure flag stays set until `fail_clr_i` is pulsed. While it is set, a write selecting code 0 is ignored.
- R10: `pclk_o[i]` carries the `cpu_clk_o` pulses when `pen_i[i]` is 1 and stays low when it is 0.
- R11: `busy_o` rises the cycle after an accepted write and falls when the handover completes. A write made while busy, or one naming the current source, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_xtal_i | input | 1 | External crystal oscillator clock |
| osc_ext_i | input | 1 | External user clock |
| osc_rc_i | input | 1 | Fast internal RC clock, also the control clock |
| osc_lrc_i | input | 1 | Slow internal RC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_rdy_i | input | 4 | Ready flag per source, indexed by source code |
| sel_wr_i | input | 1 | Source-select write strobe (fast RC domain) |
| sel_src_i | input | 2 | Requested source code |
| psc_wr_i | input | 1 | Prescaler write strobe |
| psc_code_i | input | PSC_W | Prescaler code, divide by 2^code |
| css_en_i | input | 1 | Security monitor enable |
| css_ie_i | input | 1 | Security interrupt enable |
| fail_clr_i | input | 1 | Clears the sticky failure flag |
| pen_i | input | NPER | Per-peripheral clock enables |
| mclk_o | output | 1 | Master clock |
| cpu_clk_o | output | 1 | Prescaled CPU clock |
| pclk_o | output | NPER | Gated peripheral clocks |
| cur_src_o | output | 2 | Code of the source driving the master clock |
| busy_o | output | 1 | Switch in progress |
| fail_o | output | 1 | Sticky crystal failure flag |
| irq_o | output | 1 | Security interrupt |

## Verification
The bench switches through every source and prescaler code and measures output rates by counting edges over fixed windows. It records the narrowest high and low pulse on the master clock across every handover; a mux that switched before the gate closed would show a sliver there. It holds a ready flag low to catch a design that switches early. It stops the crystal with the monitor off, then on, to catch a detector that ignores its enable or never fires. After a fallback it tries to reselect the crystal, which a design without the sticky lock would accept and then hang on a dead clock.

// File: rtl/clkctl_pkg.sv
`timescale 1ns/1ps
package clkctl_pkg;
    localparam int NSRC = 4;
    localparam int FALLBACK_CODE = 3;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_RC   = 2'd2,
        SRC_LRC  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DROP  = 2'd2,
        ST_RAISE = 2'd3
    } sw_state_e;
endpackage

// File: rtl/clkctl_chan.sv
`timescale 1ns/1ps
// One gated source channel: request synchronised on the source's rising
// edge, gate updated on its falling edge so the AND never clips a pulse.
module clkctl_chan #(
    parameter bit RST_ON = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic kill_i,
    input  logic req_i,
    output logic en_o,
    output logic gclk_o
);
    logic arst_n;
    logic req_m, req_s;
    logic en_q;

    assign arst_n = rst_n & ~kill_i;

    always_ff @(posedge clk_i or negedge arst_n) begin
        if (!arst_n) begin
            req_m <= RST_ON;
            req_s <= RST_ON;
        end else begin
            req_m <= req_i;
            req_s <= req_m;
        end
    end

    always_ff @(negedge clk_i or negedge arst_n) begin
        if (!arst_n) en_q <= RST_ON;
        else         en_q <= req_s;
    end

    assign en_o   = en_q;
    assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/clkctl_css.sv
`timescale 1ns/1ps
// Crystal watchdog: counts fast RC cycles between crystal rising edges.
module clkctl_css #(
    parameter int WIN = 64
) (
    input  logic rc_clk_i,
    input  logic xtal_i,
    input  logic rst_n,
    input  logic en_i,
    output logic timeout_o
);
    localparam int CW = $clog2(WIN + 1);

    logic       tog_q;
    logic [2:0] tog_s;
    logic       edge_seen;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge xtal_i or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    always_ff @(posedge rc_clk_i or negedge rst_n) begin
        if (!rst_n) tog_s <= '0;
        else        tog_s <= {tog_s[1:0], tog_q};
    end

    assign edge_seen = tog_s[1] ^ tog_s[2];

    always_ff @(posedge rc_clk_i or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (edge_seen || !en_i) cnt_q <= '0;
        else if (cnt_q != CW'(WIN))  cnt_q <= cnt_q + 1'b1;
    end

    assign timeout_o = (cnt_q == CW'(WIN));
endmodule

// File: rtl/clkctl_psc.sv
`timescale 1ns/1ps
// Pulse-swallowing prescaler and peripheral gates, all in the master domain.
module clkctl_psc #(
    parameter int PSC_W = 3,
    parameter int NPER  = 8
) (
    input  logic             mclk_i,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] code_i,
    input  logic [NPER-1:0]  pen_i,
    output logic             cpu_clk_o,
    output logic [NPER-1:0]  pclk_o
);
    localparam int CNT_W = (1 << PSC_W) - 1;

    logic [PSC_W-1:0] code_m, code_s, code_q;
    logic [CNT_W-1:0] cnt_q, lim;
    logic             gate_q;
    logic [NPER-1:0]  pen_m, pen_s, pen_q;

    always_ff @(posedge mclk_i or negedge rst_n) begin
        if (!rst_n) begin
            code_m <= '0;
            code_s <= '0;
            pen_m  <= '0;
            pen_s  <= '0;
        end else begin
            code_m <= code_i;
            code_s <= code_m;
            pen_m  <= pen_i;
            pen_s  <= pen_m;
        end
    end

    always_comb lim = CNT_W'((32'd1 << code_q) - 32'd1);

    always_ff @(negedge mclk_i or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= '0;
            gate_q <= 1'b0;
            pen_q  <= '0;
        end else begin
            pen_q <= pen_s;
            if (cnt_q >= lim) begin
                cnt_q  <= '0;
                code_q <= code_s;
                gate_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                gate_q <= 1'b0;
            end
        end
    end

    assign cpu_clk_o = mclk_i & gate_q;
    assign pclk_o    = {NPER{cpu_clk_o}} & pen_q;
endmodule

// File: rtl/clkctl.sv
`timescale 1ns/1ps
module clkctl
    import clkctl_pkg::*;
#(
    parameter int NPER    = 8,
    parameter int CSS_WIN = 64,
    parameter int PSC_W   = 3
) (
    input  logic             osc_xtal_i,
    input  logic             osc_ext_i,
    input  logic             osc_rc_i,
    input  logic             osc_lrc_i,
    input  logic             rst_n,
    input  logic [3:0]       src_rdy_i,
    input  logic             sel_wr_i,
    input  logic [1:0]       sel_src_i,
    input  logic             psc_wr_i,
    input  logic [PSC_W-1:0] psc_code_i,
    input  logic             css_en_i,
    input  logic             css_ie_i,
    input  logic             fail_clr_i,
    input  logic [NPER-1:0]  pen_i,
    output logic             mclk_o,
    output logic             cpu_clk_o,
    output logic [NPER-1:0]  pclk_o,
    output logic [1:0]       cur_src_o,
    output logic             busy_o,
    output logic             fail_o,
    output logic             irq_o
);
    localparam logic [NSRC-1:0] RESET_REQ = NSRC'(1) << int'(SRC_RC);

    sw_state_e        state_q, st_d;
    src_e             cur_q, cur_d, tgt_q, tgt_d, sel;
    logic [PSC_W-1:0] psc_q, psc_d;
    logic             fail_q, fail_d;
    logic [NSRC-1:0]  req_q, req_d;
    logic [NSRC-1:0]  rdy_m, rdy_s, on_m, on_s;
    logic [NSRC-1:0]  osc, chan_en, gclk, kill;
    logic             timeout, det, fb_go, sel_ok, xtal_live;

    assign osc = {osc_lrc_i, osc_rc_i, osc_ext_i, osc_xtal_i};
    assign sel = src_e'(sel_src_i);

    // Synchronise ready flags and channel gate states into the RC domain.
    always_ff @(posedge osc_rc_i or negedge rst_n) begin
        if (!rst_n) begin
            rdy_m <= '0;
            rdy_s <= '0;
            on_m  <= RESET_REQ;
            on_s  <= RESET_REQ;
        end else begin
            rdy_m <= src_rdy_i;
            rdy_s <= rdy_m;
            on_m  <= chan_en;
            on_s  <= on_m;
        end
    end

    clkctl_css #(.WIN(CSS_WIN)) u_css (
        .rc_clk_i  (osc_rc_i),
        .xtal_i    (osc_xtal_i),
        .rst_n     (rst_n),
        .en_i      (css_en_i),
        .timeout_o (timeout)
    );

    assign det       = timeout & css_en_i;
    assign xtal_live = (state_q == ST_IDLE) ? (cur_q == SRC_XTAL) : (tgt_q == SRC_XTAL);
    assign fb_go     = det & xtal_live;
    assign sel_ok    = (sel != cur_q) && !((sel == SRC_XTAL) && fail_q);
    assign fail_d    = det | (fail_q & ~fail_clr_i);

    // Next-state logic.
    always_comb begin
        st_d  = state_q;
        cur_d = cur_q;
        tgt_d = tgt_q;
        psc_d = psc_wr_i ? psc_code_i : psc_q;
        if (fb_go) begin
            st_d  = ST_DROP;
            tgt_d = SRC_RC;
            psc_d = PSC_W'(FALLBACK_CODE);
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sel_wr_i && sel_ok) begin
                        st_d  = ST_WAIT;
                        tgt_d = sel;
                    end
                end
                ST_WAIT:  if (rdy_s[tgt_q]) st_d = ST_DROP;
                ST_DROP:  if (on_s == '0)   st_d = ST_RAISE;
                ST_RAISE: begin
                    if (on_s[tgt_q]) begin
                        st_d  = ST_IDLE;
                        cur_d = tgt_q;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge osc_rc_i or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= SRC_RC;
            tgt_q   <= SRC_RC;
            psc_q   <= PSC_W'(FALLBACK_CODE);
            fail_q  <= 1'b0;
            req_q   <= RESET_REQ;
        end else begin
            state_q <= st_d;
            cur_q   <= cur_d;
            tgt_q   <= tgt_d;
            psc_q   <= psc_d;
            fail_q  <= fail_d;
            req_q   <= req_d;
        end
    end

    // Outputs: channel requests follow the next state, registered above.
    always_comb begin
        req_d = '0;
        unique case (st_d)
            ST_IDLE, ST_WAIT: req_d[cur_d] = 1'b1;
            ST_RAISE:         req_d[tgt_d] = 1'b1;
            ST_DROP:          req_d = '0;
            default:          req_d = '0;
        endcase
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign cur_src_o = cur_q;
    assign fail_o    = fail_q;
    assign irq_o     = fail_q & css_ie_i;

    for (genvar i = 0; i < NSRC; i++) begin : g_ch
        assign kill[i] = (i == int'(SRC_XTAL)) ? fail_q : 1'b0;
        clkctl_chan #(.RST_ON(i == int'(SRC_RC))) u_ch (
            .clk_i  (osc[i]),
            .rst_n  (rst_n),
            .kill_i (kill[i]),
            .req_i  (req_q[i]),
            .en_o   (chan_en[i]),
            .gclk_o (gclk[i])
        );
    end

    assign mclk_o = |gclk;

    clkctl_psc #(.PSC_W(PSC_W), .NPER(NPER)) u_psc (
        .mclk_i    (mclk_o),
        .rst_n     (rst_n),
        .code_i    (psc_q),
        .pen_i     (pen_i),
        .cpu_clk_o (cpu_clk_o),
        .pclk_o    (pclk_o)
    );
endmodule

// File: rtl/clkctl_chk.sv
`timescale 1ns/1ps
module clkctl_chk (
    input logic       osc_rc_i,
    input logic       rst_n,
    input logic       sel_wr_i,
    input logic [1:0] sel_src_i,
    input logic       css_en_i,
    input logic       fail_clr_i,
    input logic [1:0] cur_src_o,
    input logic       busy_o,
    input logic       fail_o
);
    p_src_hold_r3: assert property (@(posedge osc_rc_i) disable iff (!rst_n)
        !busy_o |=> (busy_o || $stable(cur_src_o)));

    p_no_detect_off_r6: assert property (@(posedge osc_rc_i) disable iff (!rst_n)
        (!css_en_i && !fail_o) |=> !fail_o);

    p_fallback_r7: assert property (@(posedge osc_rc_i) disable iff (!rst_n)
        ($rose(fail_o) && cur_src_o == 2'd0) |-> busy_o);

    p_sticky_r9: assert property (@(posedge osc_rc_i) disable iff (!rst_n)
        (fail_o && !fail_clr_i) |=> fail_o);

    p_xtal_block_r9: assert property (@(posedge osc_rc_i) disable iff (!rst_n)
        (fail_o && !busy_o && sel_wr_i && sel_src_i == 2'd0) |=> !busy_o);

    p_same_src_r11: assert property (@(posedge osc_rc_i) disable iff (!rst_n)
        (!busy_o && sel_wr_i && sel_src_i == cur_src_o && cur_src_o != 2'd0) |=> !busy_o);
endmodule

bind clkctl clkctl_chk u_chk (
    .osc_rc_i   (osc_rc_i),
    .rst_n      (rst_n),
    .sel_wr_i   (sel_wr_i),
    .sel_src_i  (sel_src_i),
    .css_en_i   (css_en_i),
    .fail_clr_i (fail_clr_i),
    .cur_src_o  (cur_src_o),
    .busy_o     (busy_o),
    .fail_o     (fail_o)
);

// File: tb/clkctl_tb.sv
`timescale 1ns/1ps
module clkctl_tb;
    localparam int NPER = 8;

    logic osc_xtal = 0, osc_ext = 0, osc_rc = 0, osc_lrc = 0;
    logic rst_n = 0;
    logic [3:0] src_rdy = 4'b1111;
    logic sel_wr = 0;
    logic [1:0] sel_src = 0;
    logic psc_wr = 0;
    logic [2:0] psc_code = 0;
    logic css_en = 0, css_ie = 0, fail_clr = 0;
    logic [NPER-1:0] pen = '0;
    logic mclk_o, cpu_clk_o, busy_o, fail_o, irq_o;
    logic [NPER-1:0] pclk_o;
    logic [1:0] cur_src_o;
    logic xtal_run = 1;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    clkctl #(.NPER(NPER)) u_dut (
        .osc_xtal_i(osc_xtal), .osc_ext_i(osc_ext), .osc_rc_i(osc_rc), .osc_lrc_i(osc_lrc),
        .rst_n(rst_n), .src_rdy_i(src_rdy), .sel_wr_i(sel_wr), .sel_src_i(sel_src),
        .psc_wr_i(psc_wr), .psc_code_i(psc_code), .css_en_i(css_en), .css_ie_i(css_ie),
        .fail_clr_i(fail_clr), .pen_i(pen), .mclk_o(mclk_o), .cpu_clk_o(cpu_clk_o),
        .pclk_o(pclk_o), .cur_src_o(cur_src_o), .busy_o(busy_o), .fail_o(fail_o), .irq_o(irq_o)
    );

    // 200 MHz fast RC; other sources at 8, 12 and 40 ns periods.
    always #2.5 osc_rc = ~osc_rc;
    always #6   osc_ext = ~osc_ext;
    always #20  osc_lrc = ~osc_lrc;
    always begin
        #4;
        if (xtal_run || osc_xtal) osc_xtal = ~osc_xtal;
    end

    int n_m = 0, n_c = 0;
    int n_p [NPER];
    initial for (int i = 0; i < NPER; i++) n_p[i] = 0;
    always @(posedge mclk_o) n_m++;
    always @(posedge cpu_clk_o) begin
        n_c++;
        #0.5;
        for (int i = 0; i < NPER; i++) if (pclk_o[i]) n_p[i]++;
    end

    // Narrowest pulses on the master clock.
    bit mon_on = 0;
    realtime t_last = 0, min_hi = 1.0e9, min_lo = 1.0e9;
    always @(mclk_o) begin
        if (mon_on) begin
            if (mclk_o == 1'b0) begin
                if ($realtime - t_last < min_hi) min_hi = $realtime - t_last;
            end else begin
                if ($realtime - t_last < min_lo) min_lo = $realtime - t_last;
            end
        end
        t_last = $realtime;
    end

    int dm, dc;
    int dp [NPER];

    task automatic measure(input int win);
        int m0, c0;
        int p0 [NPER];
        m0 = n_m; c0 = n_c;
        for (int i = 0; i < NPER; i++) p0[i] = n_p[i];
        #(win);
        dm = n_m - m0; dc = n_c - c0;
        for (int i = 0; i < NPER; i++) dp[i] = n_p[i] - p0[i];
        @(negedge osc_rc);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_near(input string req, input int act, input int exp, input int tol);
        n_chk++;
        if (act < exp - tol || act > exp + tol) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_sel(input logic [1:0] s);
        @(negedge osc_rc); sel_wr = 1; sel_src = s;
        @(negedge osc_rc); sel_wr = 0;
    endtask

    task automatic write_psc(input logic [2:0] c);
        @(negedge osc_rc); psc_wr = 1; psc_code = c;
        @(negedge osc_rc); psc_wr = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 4000; k++) begin
            @(negedge osc_rc);
            if (!busy_o) break;
        end
    endtask

    function automatic int src_edges(input int s, input int win);
        case (s)
            0: return win / 8;
            1: return win / 12;
            2: return win / 5;
            default: return win / 40;
        endcase
    endfunction

    initial begin
        #22 rst_n = 1;
        #200;
        @(negedge osc_rc);
        mon_on = 1;
        // R2 reset state
        chk("R2 cur_src", cur_src_o, 2);
        chk("R2 busy", busy_o, 0);
        chk("R2 fail", fail_o, 0);
        chk("R2 irq", irq_o, 0);
        measure(2000);
        chk_near("R2 mclk rate", dm, 400, 2);
        chk_near("R2 cpu rate div8", dc, 50, 2);

        // R5 prescaler sweep on the fast RC
        for (int k = 0; k < 8; k++) begin
            write_psc(3'(k));
            #1500;
            measure(2560);
            chk_near("R5 cpu pulses", dc, 512 >> k, 1);
        end
        write_psc(3'd0);

        // R1 every source, R11 busy after accepted write
        begin
            int order [4] = '{0, 1, 3, 2};
            for (int j = 0; j < 4; j++) begin
                write_sel(2'(order[j]));
                chk("R11 busy after write", busy_o, 1);
                wait_idle();
                chk("R1 cur_src", cur_src_o, order[j]);
                #200;
                measure(2400);
                chk_near("R1 mclk rate", dm, src_edges(order[j], 2400), 2);
            end
        end

        // R3 ready handshake, R11 write while busy ignored
        src_rdy[1] = 0;
        write_sel(2'd1);
        #500;
        @(negedge osc_rc);
        chk("R3 busy while not ready", busy_o, 1);
        chk("R3 cur held", cur_src_o, 2);
        measure(2400);
        chk_near("R3 mclk still fast RC", dm, 480, 2);
        write_sel(2'd3);
        src_rdy[1] = 1;
        wait_idle();
        chk("R11 busy write ignored", cur_src_o, 1);
        write_sel(2'd1);
        chk("R11 same source ignored", busy_o, 0);

        // R10 peripheral gates at divide by 4 on fast RC
        write_sel(2'd2);
        wait_idle();
        write_psc(3'd2);
        begin
            logic [NPER-1:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
            for (int j = 0; j < 4; j++) begin
                pen = pats[j];
                #300;
                measure(2000);
                for (int b = 0; b < NPER; b++)
                    chk_near("R10 pclk pulses", dp[b], pats[j][b] ? 100 : 0, 2);
            end
        end

        // R6 monitor disabled: dead crystal left alone
        write_psc(3'd0);
        write_sel(2'd0);
        wait_idle();
        chk("R1 on crystal", cur_src_o, 0);
        xtal_run = 0;
        #2000;
        @(negedge osc_rc);
        chk("R6 no flag when off", fail_o, 0);
        chk("R6 no switch when off", cur_src_o, 0);
        measure(500);
        chk("R6 master stopped", dm, 0);

        // R6/R7 enable monitor: fallback
        css_en = 1;
        #1500;
        @(negedge osc_rc);
        chk("R6 flag set", fail_o, 1);
        chk("R8 irq masked", irq_o, 0);
        chk("R7 back on fast RC", cur_src_o, 2);
        chk("R7 handover done", busy_o, 0);
        measure(2000);
        chk_near("R7 mclk fast RC", dm, 400, 2);
        chk_near("R7 cpu forced div8", dc, 50, 2);
        css_ie = 1;
        @(negedge osc_rc);
        chk("R8 irq", irq_o, 1);

        // R9 crystal locked out while flag set
        write_sel(2'd0);
        chk("R9 xtal write ignored busy", busy_o, 0);
        #300;
        @(negedge osc_rc);
        chk("R9 xtal write ignored src", cur_src_o, 2);
        xtal_run = 1;
        #500;
        @(negedge osc_rc);
        chk("R9 flag sticky", fail_o, 1);
        fail_clr = 1;
        @(negedge osc_rc);
        fail_clr = 0;
        chk("R9 flag cleared", fail_o, 0);
        chk("R8 irq cleared", irq_o, 0);
        write_sel(2'd0);
        wait_idle();
        chk("R9 xtal reselected", cur_src_o, 0);
        #2000;
        @(negedge osc_rc);
        chk("R6 running crystal no flag", fail_o, 0);

        // R4 no runt pulses over all handovers
        chk("R4 min high ps", (int'(min_hi * 1000.0) >= 2400) ? 1 : 0, 1);
        chk("R4 min low ps", (int'(min_lo * 1000.0) >= 2400) ? 1 : 0, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule